// File: doc/BRIEF.md
# System Clock Ratio Detector and Frame Resynchronizer

This block runs on the converter's system clock and watches the frame (sample-rate) clock and the bit clock. It finds out whether the system clock runs at 256 or 384 times the sample rate, with no configuration input. It also keeps a sample-phase counter that the interpolation and modulator logic use to schedule their work. A mute output tells the output stage to hold the analog outputs at the midscale (bipolar zero) level. Mute is asserted while the block is initialising, while no ratio is confirmed, and while the phase is being realigned.

The block measures the frame period in system clocks between frame-clock rising edges. It confirms a ratio only after two consecutive periods fall into the same class. At each frame-clock rising edge it compares the phase counter with its aligned value, which is zero. Small offsets are accepted and the counter runs on untouched. An offset larger than six bit-clock periods reloads the counter and mutes the outputs for one further frame. The bit-clock period used for that limit is measured continuously in system clocks.

Top module: `sysclk_ratio_sync`

## Requirements
- R1: While `rst` is high, `mute` is 1, `ratio_384` is 0 and `phase` is 0.
- R2: After `rst` falls, `mute` stays 1 through the first 1024 rising clock edges. It may fall only from the 1024th edge onward.
- R3: The frame period is the number of system clocks between two frame-clock rising edges. A period within ±48 clocks of 256 is class 256, and one within ±48 of 384 is class 384. `ratio_384` (1 = 384, 0 = 256) changes only on a frame-clock rising edge that ends the second consecutive period of the same class. A single period of a new class does not change it.
- R4: A period in neither class drops the lock, so `mute` goes to 1, and leaves `ratio_384` unchanged.
- R5: While locked, a single period of the other class drops the lock, so `mute` goes to 1.
- R6: `phase` counts 0 up to N−1 and wraps, where N is 256 or 384 from `ratio_384`. When the counter is aligned it holds 0 in the cycle of a frame-clock rising edge and 1 in the cycle after.
- R7: The tolerance is 6 × B system clocks, where B is the measured number of system clocks between bit-clock rising edges. At a frame-clock rising edge the offset is min(p, N−p), with p the phase value in that cycle. An offset at or below the tolerance leaves the counter running (it reads p+1 mod N after the edge) and does not affect `mute`.
- R8: An offset above the tolerance, early or late, reloads `phase` to 1 in the cycle after the edge and sets `mute` to 1.
- R9: After a reload or a lock acquisition, `mute` stays 1 until the next frame-clock rising edge and is 0 in the cycle after it, provided that edge is aligned and the lock holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (256 or 384 times the sample rate) |
| rst | input | 1 | Synchronous active-high power-on reset |
| lrck | input | 1 | Frame clock, synchronous to `clk` |
| bck | input | 1 | Bit clock, synchronous to `clk` |
| ratio_384 | output | 1 | Detected ratio: 1 = 384, 0 = 256 |
| phase | output | 9 | Sample-phase counter |
| mute | output | 1 | Hold outputs at midscale |

## Verification
The frame-clock rising edge can carry a period classification and a phase-offset judgement in the same cycle. When the bench shifts a frame edge by k clocks, that one period is 256+k or 384+k: it still classifies, and it also produces an offset of |k|. The bench sweeps k across the tolerance boundary on both sides at both ratios, checking that the lock survives and that the offset alone decides between free-running and reload. It also drives period changes (a new ratio, or an invalid period) on edges where the phase is aligned. There the lock decision alone must drive `mute` and `ratio_384`.

// File: rtl/sysclk_ratio_sync.sv
module sysclk_ratio_sync #(
  parameter int INIT_CYCLES = 1024,
  parameter int TOL_BCK     = 6,
  parameter int SLACK       = 48,
  parameter int R_LO        = 256,
  parameter int R_HI        = 384,
  parameter int CW          = 10,
  parameter int PW          = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lrck,
  input  logic          bck,
  output logic          ratio_384,
  output logic [PW-1:0] phase,
  output logic          mute
);
  localparam int IW = $clog2(INIT_CYCLES + 1);
  localparam int TW = CW + 4;

  logic          lr_q, bk_q;
  logic [CW-1:0] per, bper, bck_len;
  logic [IW-1:0] init_cnt;
  logic          have_prev, locked, hold;
  logic [1:0]    prev_cls, cls;

  wire lr_rise = lrck & ~lr_q;
  wire bk_rise = bck & ~bk_q;
  wire init_busy = init_cnt != IW'(INIT_CYCLES);

  logic [CW:0] meas;
  assign meas = (CW+1)'(per) + (CW+1)'(1);

  always_comb begin
    if (meas >= (CW+1)'(R_LO - SLACK) && meas <= (CW+1)'(R_LO + SLACK))
      cls = 2'd1;
    else if (meas >= (CW+1)'(R_HI - SLACK) && meas <= (CW+1)'(R_HI + SLACK))
      cls = 2'd2;
    else
      cls = 2'd0;
  end

  logic [PW:0] len, ph, off;
  assign len = ratio_384 ? (PW+1)'(R_HI) : (PW+1)'(R_LO);
  assign ph  = {1'b0, phase};
  assign off = (ph < (len >> 1)) ? ph : len - ph;

  logic [TW-1:0] tol;
  assign tol = TW'(bck_len) * TW'(TOL_BCK);

  wire [1:0] cur_cls = ratio_384 ? 2'd2 : 2'd1;
  wire same   = have_prev && cls != 2'd0 && cls == prev_cls;
  wire keep   = have_prev && locked && cls == cur_cls;
  wire lock_n = same | keep;
  wire resync = lr_rise && (!locked || !lock_n || TW'(off) > tol);

  always_ff @(posedge clk) begin
    lr_q <= lrck;
    bk_q <= bck;
    if (rst) begin
      per       <= '0;
      bper      <= '0;
      bck_len   <= '0;
      init_cnt  <= '0;
      have_prev <= 1'b0;
      locked    <= 1'b0;
      hold      <= 1'b0;
      prev_cls  <= 2'd0;
      ratio_384 <= 1'b0;
      phase     <= '0;
    end else begin
      if (init_busy) init_cnt <= init_cnt + IW'(1);

      if (bk_rise) begin
        bck_len <= bper + CW'(1);
        bper    <= '0;
      end else if (bper != '1) begin
        bper <= bper + CW'(1);
      end

      if (lr_rise) begin
        per       <= '0;
        have_prev <= 1'b1;
        prev_cls  <= have_prev ? cls : 2'd0;
        hold      <= resync;
        if (have_prev) locked <= lock_n;
        if (same) ratio_384 <= (cls == 2'd2);
      end else if (per != '1) begin
        per <= per + CW'(1);
      end

      if (resync)
        phase <= PW'(1);
      else if (ph >= len - (PW+1)'(1))
        phase <= '0;
      else
        phase <= phase + PW'(1);
    end
  end

  assign mute = rst | init_busy | ~locked | hold;
endmodule

// File: rtl/sysclk_ratio_sync_chk.sv
module sysclk_ratio_sync_chk #(
  parameter int INIT_CYCLES = 1024,
  parameter int R_LO        = 256,
  parameter int R_HI        = 384,
  parameter int PW          = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          lr_rise,
  input logic          ratio_384,
  input logic [PW-1:0] phase,
  input logic          mute
);
  int since;
  always_ff @(posedge clk) begin
    if (rst) since <= 0;
    else if (since != INIT_CYCLES) since <= since + 1;
  end

  a_r2_init_mute: assert property (@(posedge clk) disable iff (rst)
    since < INIT_CYCLES |-> mute);

  a_r6_phase_range: assert property (@(posedge clk) disable iff (rst)
    int'(phase) < (ratio_384 ? R_HI : R_LO));

  a_r3_ratio_at_edge: assert property (@(posedge clk) disable iff (rst)
    !$stable(ratio_384) |-> $past(lr_rise));

  a_r9_unmute_point: assert property (@(posedge clk) disable iff (rst)
    $fell(mute) |-> ($past(lr_rise) || (since == INIT_CYCLES && $past(since) != INIT_CYCLES)));

  a_r8_mute_reload: assert property (@(posedge clk) disable iff (rst)
    $rose(mute) |-> int'(phase) == 1);
endmodule

bind sysclk_ratio_sync sysclk_ratio_sync_chk #(
  .INIT_CYCLES(INIT_CYCLES), .R_LO(R_LO), .R_HI(R_HI), .PW(PW)
) u_chk (
  .clk(clk), .rst(rst), .lr_rise(lr_rise),
  .ratio_384(ratio_384), .phase(phase), .mute(mute)
);

// File: tb/sim_sysclk_ratio_sync.sv
module sim_sysclk_ratio_sync;
  localparam int CLK_NS = 10;

  logic clk = 0, rst = 1, lrck = 0, bck = 0;
  logic ratio_384, mute;
  logic [8:0] phase;

  sysclk_ratio_sync u0 (
    .clk(clk), .rst(rst), .lrck(lrck), .bck(bck),
    .ratio_384(ratio_384), .phase(phase), .mute(mute)
  );

  always #(CLK_NS/2) clk = ~clk;

  int fper = 256, adj = 0, fc = 0, bhalf = 2, bc = 0, cyc = 0;
  int tests = 0, fails = 0;

  always @(negedge clk) begin
    if (fc >= fper - 1 + adj) begin fc = 0; adj = 0; end
    else fc++;
    lrck = fc < fper / 2;
    if (bc >= bhalf - 1) begin bc = 0; bck = ~bck; end
    else bc++;
  end

  always @(posedge clk) if (!rst) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_rise();
    do @(posedge clk); while (fc != 0);
    #(CLK_NS/4);
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #(CLK_NS/4);
  endtask

  task automatic sweep(input int n, input int tol, input int k);
    adj = k;
    wait_rise();
    if ((k < 0 ? -k : k) <= tol) begin
      chk(int'(phase) == (k + 1 + n) % n, "R7 phase runs on", phase, (k + 1 + n) % n);
      chk(mute == 0, "R7 mute untouched", mute, 0);
      adj = -k;
      wait_rise();
      chk(int'(phase) == 1, "R6 realigned", phase, 1);
    end else begin
      chk(mute == 1, "R8 mute on reload", mute, 1);
      chk(int'(phase) == 1, "R8 phase reload", phase, 1);
      step(n / 2);
      chk(mute == 1, "R9 mute held mid-frame", mute, 1);
      wait_rise();
      chk(mute == 0, "R9 mute released", mute, 0);
      chk(int'(phase) == 1, "R9 phase aligned", phase, 1);
    end
  endtask

  initial begin
    #(CLK_NS * 190000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (40) @(negedge clk);
    chk(mute == 1, "R1 mute in reset", mute, 1);
    chk(ratio_384 == 0, "R1 ratio in reset", ratio_384, 0);
    chk(phase == 0, "R1 phase in reset", phase, 0);
    rst = 0;

    do @(negedge clk); while (cyc != 1023);
    chk(mute == 1, "R2 mute at edge 1023", mute, 1);
    @(negedge clk);
    chk(mute == 0, "R2 mute after edge 1024", mute, 0);
    chk(ratio_384 == 0, "R3 ratio 256", ratio_384, 0);

    wait_rise();
    chk(phase == 1, "R6 phase after edge", phase, 1);
    step(100);
    chk(phase == 101, "R6 phase counts", phase, 101);

    for (int k = -30; k <= 30; k++) sweep(256, 24, k);

    wait_rise();
    fper = 384; bhalf = 3;
    wait_rise();
    chk(mute == 1, "R5 other class drops lock", mute, 1);
    chk(ratio_384 == 0, "R3 one period insufficient", ratio_384, 0);
    wait_rise();
    chk(ratio_384 == 1, "R3 ratio 384", ratio_384, 1);
    chk(mute == 1, "R9 hold after lock", mute, 1);
    wait_rise();
    chk(mute == 0, "R9 release after lock", mute, 0);
    step(300);
    chk(phase == 301, "R6 phase counts at 384", phase, 301);

    for (int k = -40; k <= 40; k++)
      if (k % 4 == 0 || k == 37 || k == -37) sweep(384, 36, k);

    wait_rise();
    fper = 320;
    wait_rise();
    chk(mute == 1, "R4 invalid mutes", mute, 1);
    chk(ratio_384 == 1, "R4 ratio kept", ratio_384, 1);
    wait_rise();
    fper = 256; bhalf = 2;
    chk(mute == 1, "R4 still muted", mute, 1);
    chk(ratio_384 == 1, "R4 ratio still kept", ratio_384, 1);
    wait_rise();
    chk(ratio_384 == 1, "R3 single 256 period", ratio_384, 1);
    chk(mute == 1, "R3 unconfirmed mute", mute, 1);
    wait_rise();
    chk(ratio_384 == 0, "R3 back to 256", ratio_384, 0);
    wait_rise();
    chk(mute == 0, "R9 release at 256", mute, 0);
    chk(phase == 1, "R6 aligned at 256", phase, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule